// File: doc/BRIEF.md
# Compressed Strided Offset Generator

This block builds a packed table of address offsets for gather and scatter units. From a signed 32-bit stride it forms the sequence 0, stride, 2·stride, … for every element index below the requested length. A per-element mask, together with a polarity bit, chooses which of these offsets survive. Surviving offsets are written in index order into consecutive destination slots, starting at slot 0. When the sweep ends, the block reports how many slots it wrote. Only the low 32 bits of an offset are computed. Sums wrap modulo 2^32, and the upper half of each 64-bit destination slot is written as zero.

An operation begins with a one-cycle `start_i` pulse while the block is idle. The block takes the stride, polarity, mask and length from that same cycle. It then examines one element index per clock and presents each surviving offset on a single-cycle write port aimed at an external register file. It finishes with a one-cycle `done_o` pulse and a count that stays valid until the next operation completes.

The controller has three states. ST_IDLE waits for work. ST_RUN walks the element indices. ST_DONE raises the completion pulse. Five transitions connect them:
- START_RUN goes from ST_IDLE to ST_RUN on start with a non-zero length.
- START_EMPTY goes from ST_IDLE to ST_DONE on start with a zero length.
- STEP keeps ST_RUN in ST_RUN while indices remain.
- LAST goes from ST_RUN to ST_DONE when the final index is handled.
- RETIRE goes from ST_DONE back to ST_IDLE unconditionally.

Top module: `iota_compress`

## Requirements
- R1: After reset the block is idle: `busy_o`, `done_o` and `wr_en_o` are 0 and `count_o` is 0.
- R2: `start_i` is accepted only in ST_IDLE, and stride, polarity, mask and length are captured in that cycle. A `start_i` pulse or operand change while `busy_o` is 1 has no effect on the running operation.
- R3: The value for element index k is k·stride in the low 32 bits, with the stride taken as signed two's complement. Bits 63:32 of `wr_data_o` are 0.
- R4: Element k is kept when `mask_i[k]` equals `keep_sel_i`. Index k is examined in the k-th cycle after the accepting clock edge (k counted from 0). A kept element raises `wr_en_o` for that cycle, with `wr_addr_o` equal to the number of elements kept before it, so the slots are 0, 1, 2, … in index order.
- R5: Accumulation wraps modulo 2^32 with no carry kept. For example, stride 0xFFFFFF00 gives element 2 = 0xFFFFFE00.
- R6: The running offset advances on every examined index, whether or not the element is kept.
- R7: For a length n ≥ 1, `done_o` is 1 for exactly one cycle, n cycles after the accepting edge. In that cycle `count_o` equals the number of kept elements, and `count_o` holds that value until the next completion.
- R8: A length of 0 produces no writes, and `done_o` is 1 in the cycle right after the accepting edge, with `count_o` = 0.
- R9: A length above 64 is treated as 64. `count_o` is 7 bits and can report 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (accepted when idle) |
| stride_i | input | 32 | Signed offset increment |
| keep_sel_i | input | 1 | Mask polarity that marks an element as kept |
| mask_i | input | 64 | Per-element mask, bit k for index k |
| len_i | input | 7 | Number of element indices to sweep |
| busy_o | output | 1 | Operation in progress (ST_RUN or ST_DONE) |
| wr_en_o | output | 1 | Destination slot write strobe |
| wr_addr_o | output | 6 | Destination slot index |
| wr_data_o | output | 64 | Offset value, upper half zero |
| count_o | output | 7 | Number of slots written by the last operation |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Faults in this block show up at the ports quickly:
- A wrong running offset appears on `wr_data_o` at the very next kept element. An offset that fails to advance across dropped indices (R6) is exposed as soon as a kept element follows a dropped one.
- A stuck or skipped slot pointer shows on `wr_addr_o` at the second kept write, and later in `count_o`.
- An index counter or controller state that is off by one moves the `done_o` pulse by a cycle.

The bench therefore compares every port on every clock against a behavioural model. That pins each of these faults to the exact cycle in which it first becomes visible.

// File: rtl/iota_pkg.sv
package iota_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } iota_state_e;

endpackage

// File: rtl/iota_fsm.sv
module iota_fsm
    import iota_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        len_zero_i,
    input  logic        last_i,
    output iota_state_e state_o,
    output logic        load_o,
    output logic        run_o
);

    iota_state_e state_q;
    iota_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: START_RUN, START_EMPTY, STEP, LAST, RETIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = len_zero_i ? ST_DONE : ST_RUN;
                end
            end
            ST_RUN: begin
                if (last_i) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        state_o = state_q;
        load_o  = (state_q == ST_IDLE) && start_i;
        run_o   = (state_q == ST_RUN);
    end

    // R7
    // done_one_cycle_chk: ST_DONE always retires on the next edge
    done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |=> (state_q == ST_IDLE));

    // R2
    // start_busy_ignored_chk: a running operation is never restarted by start
    start_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !last_i) |=> (state_q == ST_RUN));

endmodule

// File: rtl/iota_stride_acc.sv
module iota_stride_acc #(
    parameter int ELEM_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic [ELEM_W-1:0] stride_i,
    output logic [ELEM_W-1:0] acc_o
);

    logic [ELEM_W-1:0] stride_q;
    logic [ELEM_W-1:0] acc_q;

    // The sum keeps only ELEM_W bits, so the carry out of the top bit is dropped
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stride_q <= '0;
            acc_q    <= '0;
        end else if (load_i) begin
            stride_q <= stride_i;
            acc_q    <= '0;
        end else if (step_i) begin
            acc_q    <= acc_q + stride_q;
        end
    end

    assign acc_o = acc_q;

    // R6
    // acc_hold_chk: the running offset only moves on a step or a load
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !step_i) |=> $stable(acc_q));

endmodule

// File: rtl/iota_pack.sv
module iota_pack #(
    parameter int MAX_LEN = 64,
    parameter int IDX_W   = 6,
    parameter int CNT_W   = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic               run_i,
    input  logic [MAX_LEN-1:0] mask_i,
    input  logic               sel_i,
    input  logic [CNT_W-1:0]   len_i,
    output logic               len_zero_o,
    output logic               keep_o,
    output logic               last_o,
    output logic [IDX_W-1:0]   idx_o,
    output logic [CNT_W-1:0]   ptr_o,
    output logic [CNT_W-1:0]   cnt_o
);

    localparam logic [CNT_W-1:0] LEN_CAP = CNT_W'(MAX_LEN);

    logic [MAX_LEN-1:0] mask_q;
    logic               sel_q;
    logic [CNT_W-1:0]   len_q;
    logic [IDX_W-1:0]   idx_q;
    logic [CNT_W-1:0]   ptr_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   len_eff;
    logic               keep;
    logic               last;

    always_comb begin
        len_eff = (len_i > LEN_CAP) ? LEN_CAP : len_i;
        keep    = (mask_q[idx_q] == sel_q);
        last    = run_i && (CNT_W'(idx_q) == len_q - CNT_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            sel_q  <= 1'b0;
            len_q  <= '0;
            idx_q  <= '0;
            ptr_q  <= '0;
            cnt_q  <= '0;
        end else if (load_i) begin
            mask_q <= mask_i;
            sel_q  <= sel_i;
            len_q  <= len_eff;
            idx_q  <= '0;
            ptr_q  <= '0;
            if (len_i == '0) begin
                cnt_q <= '0;
            end
        end else if (run_i) begin
            idx_q <= idx_q + IDX_W'(1);
            ptr_q <= ptr_q + CNT_W'(keep);
            if (last) begin
                cnt_q <= ptr_q + CNT_W'(keep);
            end
        end
    end

    assign len_zero_o = (len_i == '0);
    assign keep_o     = keep;
    assign last_o     = last;
    assign idx_o      = idx_q;
    assign ptr_o      = ptr_q;
    assign cnt_o      = cnt_q;

    // R4
    // ptr_behind_idx_chk: slots written never outnumber indices examined
    ptr_behind_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (ptr_q <= CNT_W'(idx_q)));

    // R7
    // cnt_hold_chk: the reported count only changes when an operation is running or loaded
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !load_i) |=> $stable(cnt_q));

    // R9
    // len_cap_chk: the captured length never exceeds the table depth
    len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (len_q <= LEN_CAP));

endmodule

// File: rtl/iota_compress.sv
module iota_compress
    import iota_pkg::*;
#(
    parameter int MAX_LEN = 64,
    parameter int ELEM_W  = 32,
    parameter int SLOT_W  = 64,
    localparam int IDX_W  = $clog2(MAX_LEN),
    localparam int CNT_W  = $clog2(MAX_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [ELEM_W-1:0]  stride_i,
    input  logic               keep_sel_i,
    input  logic [MAX_LEN-1:0] mask_i,
    input  logic [CNT_W-1:0]   len_i,
    output logic               busy_o,
    output logic               wr_en_o,
    output logic [IDX_W-1:0]   wr_addr_o,
    output logic [SLOT_W-1:0]  wr_data_o,
    output logic [CNT_W-1:0]   count_o,
    output logic               done_o
);

    iota_state_e       state;
    logic              load;
    logic              run;
    logic              len_zero;
    logic              keep;
    logic              last;
    logic [IDX_W-1:0]  idx;
    logic [CNT_W-1:0]  ptr;
    logic [CNT_W-1:0]  cnt;
    logic [ELEM_W-1:0] acc;

    iota_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .len_zero_i (len_zero),
        .last_i     (last),
        .state_o    (state),
        .load_o     (load),
        .run_o      (run)
    );

    iota_stride_acc #(.ELEM_W(ELEM_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .step_i   (run),
        .stride_i (stride_i),
        .acc_o    (acc)
    );

    iota_pack #(.MAX_LEN(MAX_LEN), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .run_i      (run),
        .mask_i     (mask_i),
        .sel_i      (keep_sel_i),
        .len_i      (len_i),
        .len_zero_o (len_zero),
        .keep_o     (keep),
        .last_o     (last),
        .idx_o      (idx),
        .ptr_o      (ptr),
        .cnt_o      (cnt)
    );

    generate
        if (SLOT_W > ELEM_W) begin : g_pad
            assign wr_data_o = {{(SLOT_W - ELEM_W){1'b0}}, acc};
        end else begin : g_trunc
            assign wr_data_o = acc[SLOT_W-1:0];
        end
    endgenerate

    always_comb begin
        busy_o    = (state != ST_IDLE);
        done_o    = (state == ST_DONE);
        wr_en_o   = run && keep;
        wr_addr_o = ptr[IDX_W-1:0];
        count_o   = cnt;
    end

    // R3
    // first_elem_zero_chk: index 0 always carries a zero offset
    first_elem_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && idx == '0) |-> (acc == '0));

    // R4
    // slot_order_chk: a write never targets a slot beyond its element index
    slot_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (CNT_W'(wr_addr_o) <= CNT_W'(idx)));

    // R2
    // write_when_busy_chk: writes only happen during an operation
    write_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> busy_o);

    // R9
    // count_range_chk: the reported count fits the table depth
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (count_o <= CNT_W'(MAX_LEN)));

endmodule

// File: tb/test_iota_compress.sv
module test_iota_compress;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] stride_i = '0;
    logic        keep_sel_i = 1'b0;
    logic [63:0] mask_i = '0;
    logic [6:0]  len_i = '0;
    logic        busy_o;
    logic        wr_en_o;
    logic [5:0]  wr_addr_o;
    logic [63:0] wr_data_o;
    logic [6:0]  count_o;
    logic        done_o;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    iota_compress i_iota_compress (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .stride_i   (stride_i),
        .keep_sel_i (keep_sel_i),
        .mask_i     (mask_i),
        .len_i      (len_i),
        .busy_o     (busy_o),
        .wr_en_o    (wr_en_o),
        .wr_addr_o  (wr_addr_o),
        .wr_data_o  (wr_data_o),
        .count_o    (count_o),
        .done_o     (done_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Run one operation and compare every port on every cycle against the model.
    // poke: during the sweep, raise start with different operands (R2).
    task automatic run_op(input logic [31:0] stride, input bit sel,
                          input logic [63:0] mask, input int len, input bit poke);
        int eff;
        int kept;
        logic [63:0] prod;
        bit keep;
        eff  = (len > 64) ? 64 : len;
        kept = 0;
        @(negedge clk);
        stride_i   = stride;
        keep_sel_i = sel;
        mask_i     = mask;
        len_i      = 7'(len);
        start_i    = 1'b1;
        @(negedge clk);
        start_i    = 1'b0;
        stride_i   = 32'h1234_5678;
        mask_i     = ~mask;
        for (int k = 0; k < eff; k++) begin
            keep = (mask[k] == sel);
            prod = 64'(k) * {32'h0, stride};
            chk(wr_en_o == keep, "R4", "wr_en", longint'(wr_en_o), longint'(keep));
            if (keep) begin
                chk(wr_addr_o == 6'(kept), "R4", "wr_addr", longint'(wr_addr_o), longint'(kept));
                chk(wr_data_o == {32'h0, prod[31:0]}, (k > 0 && mask[k-1] != sel) ? "R6" : "R3",
                    "wr_data", longint'(wr_data_o), longint'({32'h0, prod[31:0]}));
                kept++;
            end
            chk(done_o == 1'b0 && busy_o == 1'b1, "R7", "done/busy mid", longint'({done_o, busy_o}), 1);
            if (poke && k == 1) begin
                start_i  = 1'b1;
                len_i    = 7'd3;
                keep_sel_i = ~sel;
            end
            @(negedge clk);
            start_i = 1'b0;
        end
        chk(wr_en_o == 1'b0, (eff == 0) ? "R8" : "R7", "wr_en at done", longint'(wr_en_o), 0);
        chk(done_o == 1'b1, (eff == 0) ? "R8" : "R7", "done", longint'(done_o), 1);
        chk(count_o == 7'(kept), (len > 64) ? "R9" : "R7", "count", longint'(count_o), longint'(kept));
        @(negedge clk);
        chk(done_o == 1'b0 && busy_o == 1'b0, "R7", "done pulse width", longint'({done_o, busy_o}), 0);
        chk(count_o == 7'(kept), "R7", "count hold", longint'(count_o), longint'(kept));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy_o == 1'b0 && done_o == 1'b0 && wr_en_o == 1'b0, "R1", "idle outputs",
            longint'({busy_o, done_o, wr_en_o}), 0);
        chk(count_o == 7'd0, "R1", "count at reset", longint'(count_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o == 1'b0, "R1", "idle after release", longint'(busy_o), 0);

        run_op(32'd1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 8, 1'b0);           // R3 dense
        run_op(32'hFFFF_FFFD, 1'b0, 64'hAAAA_AAAA_AAAA_AAAA, 64, 1'b0);  // R6 alternating, negative
        run_op(32'd0, 1'b1, 64'h0000_0000_0000_00F3, 10, 1'b0);          // zero stride
        run_op(32'hFFFF_FF00, 1'b1, 64'h0000_0000_0000_0005, 4, 1'b0);   // R5 wrap
        run_op(32'h7FFF_FFFF, 1'b0, 64'h0000_0000_0000_0010, 9, 1'b0);   // R5 positive wrap
        run_op(32'd7, 1'b1, 64'h0, 5, 1'b0);                             // nothing kept
        run_op(32'd4, 1'b1, 64'hDEAD_BEEF_0000_0001, 0, 1'b0);           // R8
        run_op(32'd2, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64, 1'b0);          // R9 count 64
        run_op(32'd3, 1'b0, 64'h0F0F_0000_0000_0000, 100, 1'b0);         // R9 clamp
        run_op(32'd5, 1'b1, 64'h0000_0000_0000_0036, 7, 1'b1);           // R2 start while busy

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule